// File: doc/BRIEF.md
# Protection Page Register File

This block holds the small byte-wide register space that governs memory access permissions, together with a 16-byte identification area. It has 32 entries. Entries 00h to 0Fh form the protection page and entries 10h to 1Fh form the ID page. A transaction layer above it decodes the serial bus bit by bit and delivers whole bytes to this block: a start marker, a device byte, a word address, data bytes and read requests. The block answers each byte with an acknowledge decision, and it returns read data when a read is requested.

The block applies the write rule of each bit. Per-block sticky bits are volatile and can only be cleared. Once a sticky bit is clear, its byte is frozen. Two detection status bits are emulated. Two fixed bytes ignore all writes. Any transfer of more than one byte is refused. The permission fields, the sticky bits and the block-0 page write enables are driven out continuously for the access checker. An active-low protect input holds the transaction logic in reset and sets all sticky bits to 1. It does not disturb the stored fields, which model nonvolatile cells.

Top module: `prot_page_regs`

## Requirements
- R1: A device byte of B8h (write) or B9h (read) following a start is acknowledged. Any other device byte is not acknowledged, and every later byte of that transaction is not acknowledged either.
- R2: A word address with any of bits 7:5 set is not acknowledged. Addresses 00h to 1Fh are acknowledged and become the pointer used by later reads, including reads in a later transaction.
- R3: A transaction carries at most one data byte. The first write data byte is acknowledged and applied. A second data byte is not acknowledged and has no effect. A second read request in one transaction is not acknowledged, and resp_data reads 00h for it.
- R4: In bytes 0 to 7, bit 7 is the block sticky bit, bits 5:4 are a read/write auxiliary field and bits 1:0 are the block permission field. In byte 8, bit 7 is the page sticky bit and bits 1:0 are the page permission field. All other bits of these bytes read 0. blk_perm[2i+1:2i] mirrors byte i, and page_perm mirrors byte 8.
- R5: Sticky bits are 1 after reset. Writing bit 7 as 0 clears the sticky bit. Writing bit 7 as 1 leaves it unchanged. While a byte's sticky bit is 0, writes to that byte are acknowledged and change nothing.
- R6: While lock_clr_n is low, all sticky bits become 1 one cycle later, bytes receive no response, and the permission fields and page enables keep their values.
- R7: Byte 9 bit i is the write enable of block-0 page i. It is read/write and drives pg_wen[i].
- R8: Byte 10 bit 7 is a detect enable: read/write, and 0 after reset. Bit 6 is a detect status bit: 1 after reset, read-only, and cleared when a write sets bit 7. Once cleared it stays 0. Bits 5:0 read 0, including bit 0.
- R9: Byte 14 always reads FFh and byte 15 always reads 10h. Writes to either are acknowledged and ignored.
- R10: Bytes 11 to 13 and 16 to 31 are ordinary read/write storage.
- R11: After reset, all permission fields and auxiliary fields are 11b and the page enables are FFh, which is the erased state.
- R12: A byte or read request that arrives outside a transaction (after a stop, before any start) produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| lock_clr_n | input | 1 | Active-low protect: holds the transaction logic in reset and sets the sticky bits |
| txn_start | input | 1 | Start or repeated-start marker |
| txn_stop | input | 1 | Stop marker |
| byte_vld | input | 1 | A byte from the master is present on byte_in |
| byte_in | input | 8 | Received byte |
| rd_req | input | 1 | Master requests one read data byte |
| resp_vld | output | 1 | Response to a byte or read request |
| resp_ack | output | 1 | 1 for acknowledge, 0 for refusal |
| resp_data | output | 8 | Read data, 00h unless this is an acknowledged read |
| blk_perm | output | 16 | Permission field of each block, 2 bits per block |
| page_perm | output | 2 | Permission field of the protection and ID pages |
| sticky | output | 9 | Sticky bits: blocks 0 to 7, then the page sticky bit |
| pg_wen | output | 8 | Block-0 page write enables |

## Verification
An input sampled at one rising edge is answered after the second rising edge that follows: the response pulse, the read data, and any change a write makes to the permission and enable outputs all appear together. The bench drives each input from one falling edge to the next and samples two falling edges later, so every observation falls inside the single cycle in which the response is valid. A sticky bit set by the protect input is checked after a whole cycle at low. The bench checks every address against its own model of the bit rules in several write-then-read sweeps.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int NBLK_DEF = 8;
  localparam int AW_DEF   = 5;
  localparam int DW_DEF   = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_WADR, S_WDAT, S_WXTRA, S_RDAT, S_RXTRA, S_SKIP
  } seq_e;

  typedef enum logic [1:0] {
    SRC_CTL, SRC_RAM, SRC_FF, SRC_REV
  } src_e;
endpackage

// File: rtl/ppr_seq.sv
module ppr_seq
  import ppr_pkg::*;
#(
  parameter int AW = AW_DEF,
  parameter int DW = DW_DEF,
  parameter logic [DW-2:0] DEV_ID = 7'h5C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          start,
  input  logic          stop,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_in,
  input  logic          rd_req,
  output logic          pre_vld,
  output logic          pre_ack,
  output logic          pre_rd,
  output logic          op_wr,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  seq_e st;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st      <= S_IDLE;
      pre_vld <= 1'b0;
      pre_ack <= 1'b0;
      pre_rd  <= 1'b0;
      op_wr   <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      pre_vld <= 1'b0;
      pre_ack <= 1'b0;
      pre_rd  <= 1'b0;
      op_wr   <= 1'b0;
      if (start) begin
        st <= S_DEV;
      end else if (stop) begin
        st <= S_IDLE;
      end else if (byte_vld || rd_req) begin
        pre_vld <= (st != S_IDLE);
        case (st)
          S_DEV: if (byte_vld) begin
            if (byte_in[DW-1:1] == DEV_ID) begin
              pre_ack <= 1'b1;
              st      <= byte_in[0] ? S_RDAT : S_WADR;
            end else begin
              st <= S_SKIP;
            end
          end
          S_WADR: if (byte_vld) begin
            if (byte_in[DW-1:AW] == '0) begin
              pre_ack <= 1'b1;
              op_addr <= byte_in[AW-1:0];
              st      <= S_WDAT;
            end else begin
              st <= S_SKIP;
            end
          end
          S_WDAT: if (byte_vld) begin
            pre_ack <= 1'b1;
            op_wr   <= 1'b1;
            op_data <= byte_in;
            st      <= S_WXTRA;
          end
          S_RDAT: if (rd_req) begin
            pre_ack <= 1'b1;
            pre_rd  <= 1'b1;
            st      <= S_RXTRA;
          end
          default: ;
        endcase
      end
    end
  end

  // R12: a response is only ever produced for a byte or request seen one edge earlier
  assert_resp_has_cause_R12: assert property (@(posedge clk) disable iff (rst)
    pre_vld |-> $past(byte_vld || rd_req));

  // R3: after a write strobe the transaction accepts no second write strobe without a new start
  assert_single_write_R3: assert property (@(posedge clk) disable iff (rst)
    (op_wr && !start) |=> !op_wr);
endmodule

// File: rtl/ppr_ctl.sv
module ppr_ctl
  import ppr_pkg::*;
#(
  parameter int NBLK = NBLK_DEF,
  parameter int AW   = AW_DEF,
  parameter int DW   = DW_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rd_byte,
  output logic [2*NBLK-1:0] blk_perm,
  output logic [1:0]      page_perm,
  output logic [NBLK:0]   sticky,
  output logic [NBLK-1:0] pg_wen
);
  localparam logic [AW-1:0] A_PAGE = AW'(NBLK);
  localparam logic [AW-1:0] A_WEN  = AW'(NBLK + 1);
  localparam logic [AW-1:0] A_DET  = AW'(NBLK + 2);

  logic [1:0]      pb  [NBLK+1];
  logic [1:0]      aux [NBLK];
  logic [NBLK:0]   stk;
  logic [NBLK-1:0] wpn;
  logic            de, dc;

  always_ff @(posedge clk) begin
    if (rst) begin
      stk <= '1;
      wpn <= '1;
      de  <= 1'b0;
      dc  <= 1'b1;
      for (int i = 0; i <= NBLK; i++) pb[i] <= 2'b11;
      for (int i = 0; i < NBLK; i++) aux[i] <= 2'b11;
    end else if (hold) begin
      stk <= '1;
    end else if (wr_en) begin
      for (int i = 0; i <= NBLK; i++) begin
        if (addr == AW'(i) && stk[i]) begin
          pb[i]  <= wdata[1:0];
          stk[i] <= wdata[DW-1];
        end
      end
      for (int i = 0; i < NBLK; i++) begin
        if (addr == AW'(i) && stk[i]) aux[i] <= wdata[5:4];
      end
      if (addr == A_WEN) wpn <= wdata[NBLK-1:0];
      if (addr == A_DET) begin
        de <= wdata[DW-1];
        if (wdata[DW-1]) dc <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NBLK; i++) begin
      if (addr == AW'(i)) rd_byte = {stk[i], 1'b0, aux[i], 2'b00, pb[i]};
    end
    if (addr == A_PAGE) rd_byte = {stk[NBLK], 5'b0, pb[NBLK]};
    if (addr == A_WEN)  rd_byte = DW'(wpn);
    if (addr == A_DET)  rd_byte = {de, dc, 6'b0};
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_perm
    assign blk_perm[2*g +: 2] = pb[g];
  end
  assign page_perm = pb[NBLK];
  assign sticky    = stk;
  assign pg_wen    = wpn;

  // R5: outside the protect hold, no sticky bit ever returns to 1
  assert_sticky_no_rise_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(hold) |-> ((stk & ~$past(stk)) == '0));

  // R6: a cycle of protect hold leaves every sticky bit set
  assert_hold_sets_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    hold |=> (&stk));

  // R6: permission fields move only after a write strobe
  assert_perm_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable({blk_perm, page_perm, pg_wen}));

  // R8: the detect status is never 1 while the enable is 1
  assert_detect_clears_R8: assert property (@(posedge clk) disable iff (rst)
    de |-> !dc);
endmodule

// File: rtl/ppr_ram.sv
module ppr_ram
  import ppr_pkg::*;
#(
  parameter int AW = AW_DEF,
  parameter int DW = DW_DEF
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/prot_page_regs.sv
module prot_page_regs
  import ppr_pkg::*;
#(
  parameter int NBLK = NBLK_DEF,
  parameter int AW   = AW_DEF,
  parameter int DW   = DW_DEF,
  parameter logic [DW-2:0] DEV_ID   = 7'h5C,
  parameter logic [DW-1:0] RO_FILL  = 8'hFF,
  parameter logic [DW-1:0] REV_CODE = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_clr_n,
  input  logic              txn_start,
  input  logic              txn_stop,
  input  logic              byte_vld,
  input  logic [DW-1:0]     byte_in,
  input  logic              rd_req,
  output logic              resp_vld,
  output logic              resp_ack,
  output logic [DW-1:0]     resp_data,
  output logic [2*NBLK-1:0] blk_perm,
  output logic [1:0]        page_perm,
  output logic [NBLK:0]     sticky,
  output logic [NBLK-1:0]   pg_wen
);
  localparam logic [AW-1:0] A_ID  = AW'(2 ** (AW - 1));
  localparam logic [AW-1:0] A_RO  = A_ID - AW'(2);
  localparam logic [AW-1:0] A_REV = A_ID - AW'(1);
  localparam logic [AW-1:0] A_RSV = AW'(NBLK + 3);

  logic          hold;
  logic          pre_vld, pre_ack, pre_rd, op_wr;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          ram_sel;
  logic [DW-1:0] ctl_byte, ctl_q, ram_q;
  logic          rd_q;
  src_e          src_d, src_q;

  assign hold = !lock_clr_n;

  ppr_seq #(.AW(AW), .DW(DW), .DEV_ID(DEV_ID)) u_seq (
    .clk(clk), .rst(rst), .hold(hold),
    .start(txn_start), .stop(txn_stop),
    .byte_vld(byte_vld), .byte_in(byte_in), .rd_req(rd_req),
    .pre_vld(pre_vld), .pre_ack(pre_ack), .pre_rd(pre_rd),
    .op_wr(op_wr), .op_addr(op_addr), .op_data(op_data)
  );

  assign ram_sel = ((op_addr >= A_RSV) && (op_addr < A_RO)) || (op_addr >= A_ID);

  ppr_ctl #(.NBLK(NBLK), .AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rst(rst), .hold(hold),
    .wr_en(op_wr && !ram_sel), .addr(op_addr), .wdata(op_data),
    .rd_byte(ctl_byte),
    .blk_perm(blk_perm), .page_perm(page_perm),
    .sticky(sticky), .pg_wen(pg_wen)
  );

  ppr_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(op_wr && ram_sel && !hold),
    .addr(op_addr), .wdata(op_data), .q(ram_q)
  );

  always_comb begin
    src_d = SRC_CTL;
    if (op_addr == A_RO)       src_d = SRC_FF;
    else if (op_addr == A_REV) src_d = SRC_REV;
    else if (ram_sel)          src_d = SRC_RAM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_vld <= 1'b0;
      resp_ack <= 1'b0;
      rd_q     <= 1'b0;
      src_q    <= SRC_CTL;
      ctl_q    <= '0;
    end else begin
      resp_vld <= pre_vld && !hold;
      resp_ack <= pre_ack && !hold;
      rd_q     <= pre_rd && !hold;
      src_q    <= src_d;
      ctl_q    <= ctl_byte;
    end
  end

  always_comb begin
    resp_data = '0;
    if (rd_q) begin
      case (src_q)
        SRC_RAM: resp_data = ram_q;
        SRC_FF:  resp_data = RO_FILL;
        SRC_REV: resp_data = REV_CODE;
        default: resp_data = ctl_q;
      endcase
    end
  end

  // R3: data appears only on an acknowledged response
  assert_data_only_on_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (resp_data != '0) |-> (resp_vld && resp_ack));

  // R9: the fixed read-only byte returns its fill value
  assert_fixed_byte_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_q && $past(op_addr) == A_RO) |-> (resp_data == RO_FILL));

  // R6: nothing is answered while the protect input is low
  assert_hold_silent_R6: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> !resp_vld);
endmodule

// File: tb/sim_prot_page_regs.sv
`timescale 1ns/1ps
module sim_prot_page_regs;
  logic       clk = 1'b0;
  logic       rst, lock_clr_n, txn_start, txn_stop, byte_vld, rd_req;
  logic [7:0] byte_in;
  logic       resp_vld, resp_ack;
  logic [7:0] resp_data;
  logic [15:0] blk_perm;
  logic [1:0] page_perm;
  logic [8:0] sticky;
  logic [7:0] pg_wen;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  prot_page_regs u0 (
    .clk(clk), .rst(rst), .lock_clr_n(lock_clr_n),
    .txn_start(txn_start), .txn_stop(txn_stop),
    .byte_vld(byte_vld), .byte_in(byte_in), .rd_req(rd_req),
    .resp_vld(resp_vld), .resp_ack(resp_ack), .resp_data(resp_data),
    .blk_perm(blk_perm), .page_perm(page_perm), .sticky(sticky), .pg_wen(pg_wen)
  );

  // bench model of the register rules
  logic [1:0] m_pb  [9];
  logic [1:0] m_aux [8];
  logic [8:0] m_st;
  logic [7:0] m_wpn;
  logic       m_de, m_dc;
  logic [7:0] m_ram [32];

  function automatic logic [7:0] exp_rd(input int a);
    if (a < 8)   return {m_st[a], 1'b0, m_aux[a], 2'b00, m_pb[a]};
    if (a == 8)  return {m_st[8], 5'b0, m_pb[8]};
    if (a == 9)  return m_wpn;
    if (a == 10) return {m_de, m_dc, 6'b0};
    if (a == 14) return 8'hFF;
    if (a == 15) return 8'h10;
    return m_ram[a];
  endfunction

  task automatic m_wr(input int a, input logic [7:0] d);
    if (a <= 8) begin
      if (m_st[a]) begin
        m_pb[a] = d[1:0];
        if (a < 8) m_aux[a] = d[5:4];
        m_st[a] = d[7];
      end
    end else if (a == 9) m_wpn = d;
    else if (a == 10) begin
      m_de = d[7];
      if (d[7]) m_dc = 1'b0;
    end else if (a != 14 && a != 15) m_ram[a] = d;
  endtask

  function automatic logic [15:0] exp_perm();
    logic [15:0] v;
    for (int i = 0; i < 8; i++) v[2*i +: 2] = m_pb[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); txn_start = 1'b1;
    @(negedge clk); txn_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); txn_stop = 1'b1;
    @(negedge clk); txn_stop = 1'b0;
  endtask

  // drive one byte, sample two edges later
  task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
    @(negedge clk); byte_in = b; byte_vld = 1'b1;
    @(negedge clk); byte_vld = 1'b0;
    @(negedge clk);
    chk(tag, {resp_vld, resp_ack}, {1'b1, exp_ack});
  endtask

  task automatic send_quiet(input logic [7:0] b, input string tag);
    @(negedge clk); byte_in = b; byte_vld = 1'b1;
    @(negedge clk); byte_vld = 1'b0;
    @(negedge clk);
    chk(tag, resp_vld, 1'b0);
  endtask

  task automatic rdreq(input logic exp_ack, input logic [7:0] exp_d, input string tag);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk);
    chk(tag, {resp_vld, resp_ack, resp_data}, {1'b1, exp_ack, exp_d});
  endtask

  task automatic do_write(input int a, input logic [7:0] d, input string tag);
    pulse_start();
    send(8'hB8, 1'b1, tag);
    send(8'(a), 1'b1, tag);
    send(d, 1'b1, tag);
    pulse_stop();
    m_wr(a, d);
  endtask

  task automatic do_read(input int a, input string tag);
    pulse_start();
    send(8'hB8, 1'b1, tag);
    send(8'(a), 1'b1, tag);
    pulse_start();
    send(8'hB9, 1'b1, tag);
    rdreq(1'b1, exp_rd(a), tag);
    pulse_stop();
  endtask

  task automatic chk_ports(input string tag);
    chk({tag, " R4 blk_perm"}, blk_perm, exp_perm());
    chk({tag, " R4 page_perm"}, page_perm, m_pb[8]);
    chk({tag, " R5 sticky"}, sticky, m_st);
    chk({tag, " R7 pg_wen"}, pg_wen, m_wpn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; lock_clr_n = 1'b1; txn_start = 1'b0; txn_stop = 1'b0;
    byte_vld = 1'b0; rd_req = 1'b0; byte_in = 8'h00;
    m_st = '1; m_wpn = 8'hFF; m_de = 1'b0; m_dc = 1'b1;
    for (int i = 0; i < 9; i++) m_pb[i] = 2'b11;
    for (int i = 0; i < 8; i++) m_aux[i] = 2'b11;
    for (int i = 0; i < 32; i++) m_ram[i] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R11: erased state after reset
    chk("R11 blk_perm reset", blk_perm, 16'hFFFF);
    chk("R11 page_perm reset", page_perm, 2'b11);
    chk("R11 pg_wen reset", pg_wen, 8'hFF);
    chk("R5 sticky reset", sticky, 9'h1FF);
    chk("R12 idle resp", resp_vld, 1'b0);

    // R12: no response outside a transaction
    send_quiet(8'hB8, "R12 byte before start");

    // R1: device codes
    pulse_start(); send(8'hA8, 1'b0, "R1 foreign code"); send(8'h00, 1'b0, "R1 after foreign"); pulse_stop();
    pulse_start(); send(8'hBA, 1'b0, "R1 near code"); pulse_stop();

    // R2: address range and pointer persistence
    pulse_start(); send(8'hB8, 1'b1, "R1 write code"); send(8'h20, 1'b0, "R2 addr 20h"); pulse_stop();
    pulse_start(); send(8'hB8, 1'b1, "R1 write code"); send(8'hE5, 1'b0, "R2 addr E5h"); pulse_stop();
    pulse_start(); send(8'hB8, 1'b1, "R2 set ptr"); send(8'h0F, 1'b1, "R2 addr 0Fh"); pulse_stop();
    pulse_start(); send(8'hB9, 1'b1, "R1 read code"); rdreq(1'b1, 8'h10, "R2 R9 ptr kept revision"); pulse_stop();
    do_read(14, "R9 byte 14");

    // R8: detection bits
    do_read(10, "R8 detect reset");
    do_write(10, 8'h81, "R8 set enable");
    do_read(10, "R8 status cleared");
    do_write(10, 8'h00, "R8 enable off");
    do_read(10, "R8 status stays 0");

    // R3: single byte only
    pulse_start(); send(8'hB8, 1'b1, "R3"); send(8'h0B, 1'b1, "R3");
    send(8'h5A, 1'b1, "R3 first data"); send(8'hA5, 1'b0, "R3 second data"); pulse_stop();
    m_wr(11, 8'h5A);
    pulse_start(); send(8'hB8, 1'b1, "R3"); send(8'h0B, 1'b1, "R3"); pulse_start();
    send(8'hB9, 1'b1, "R3"); rdreq(1'b1, 8'h5A, "R3 R10 first read");
    rdreq(1'b0, 8'h00, "R3 second read"); pulse_stop();
    pulse_start(); send(8'hB9, 1'b1, "R3"); send(8'h33, 1'b0, "R3 byte in read txn"); pulse_stop();

    // sweeps over every address against the bench model (R4 R5 R7 R8 R9 R10)
    for (int a = 0; a < 32; a++) begin
      do_write(a, 8'(a * 53 + 7) | 8'h80, "R10 sweep1 write");
      do_read(a, "R4 R10 sweep1 read");
    end
    chk_ports("sweep1");
    for (int a = 0; a < 32; a++) begin
      do_write(a, 8'(a * 29 + 3), "R5 sweep2 write");
      chk_ports("sweep2");
    end
    for (int a = 0; a < 32; a++) do_read(a, "R5 R9 sweep2 read");
    for (int a = 0; a < 32; a++) begin
      do_write(a, 8'hFF, "R5 frozen write");
      do_read(a, "R5 frozen read");
    end
    chk_ports("sweep3");

    // R5: explicit clear then freeze on block 2
    do_write(2, 8'h01, "R5 clear");
    chk("R5 sticky after clear", sticky[2], 1'b0);
    chk("R4 block2 perm", blk_perm[5:4], m_pb[2]);
    do_write(2, 8'h83, "R5 frozen");
    chk("R5 block2 frozen", blk_perm[5:4], m_pb[2]);

    // R6: protect input
    @(negedge clk); lock_clr_n = 1'b0;
    @(negedge clk); txn_start = 1'b1;
    @(negedge clk); txn_start = 1'b0;
    send_quiet(8'hB8, "R6 byte during hold");
    m_st = '1;
    chk_ports("R6 hold");
    @(negedge clk); lock_clr_n = 1'b1;
    do_write(2, 8'h82, "R6 writable again");
    chk("R6 block2 after release", blk_perm[5:4], 2'b10);
    chk_ports("R6 after release");
    do_read(2, "R6 R4 block2 read");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule